// File: doc/BRIEF.md
# Opcode-Driven 4-Bit Arithmetic and Logic Unit

This block is a purely combinational arithmetic and logic unit with two 4-bit operands, a carry-in bit and a 4-bit operation select. It returns a 4-bit result, a carry-out flag, a zero flag and a 16-bit display word meant to drive a row of indicator lights. Addition and subtraction, each with or without the incoming carry, share one ripple-carry adder made of 1-bit full adders. Subtraction feeds the inverted second operand into that adder with an adjusted carry-in, which is the two's complement of B.

The other selects cover shifts and rotates by a variable amount taken from operand B, five bitwise logic functions, a forced-zero mode and a display mode. In display mode the 16-bit word shows two fixed 8-bit ASCII character codes. In every other mode it mirrors the result and the two flags. Outputs follow the inputs with no clock, so the block can sit in any single-cycle datapath.

Top module: `alu4_core`

## Requirements
- R1: Select 0000 gives {carry_out, result} = A + B. Select 0001 gives {carry_out, result} = A + B + carry_in.
- R2: Select 0010 gives result = A − B, with carry_out = 1 exactly when A ≥ B. Select 0011 computes A + ~B + (1 − carry_in), so result = A − B − carry_in, and carry_out = 1 exactly when no borrow occurs (A ≥ B + carry_in).
- R3: Select 0100 shifts A right logically by B and select 1110 shifts A left logically by B, filling with zeros. For B ≥ 4 the result is 0000.
- R4: Select 0101 shifts A right arithmetically by B, replicating A[3]. For B ≥ 4 the result is four copies of A[3].
- R5: Select 0110 rotates A right and select 1111 rotates A left, both by B modulo 4.
- R6: Bitwise logic: 1000 gives A OR B, 1001 gives A AND B, 1010 gives A XOR B, 1011 gives NOT A, and 1101 gives A NAND B.
- R7: Select 0111 forces the result to 0000 whatever the operands and carry_in are.
- R8: carry_out is 0 for every select from 0100 through 1111.
- R9: zero_flag is 1 exactly when the 4-bit result is 0000.
- R10: Select 1100 drives led_word with 16'h4F4B: ASCII 'O' (0x4F) in bits 15:8 and ASCII 'K' (0x4B) in bits 7:0. In this mode result is 0000 and carry_out is 0.
- R11: For every select other than 1100, led_word bit 15 is zero_flag, bit 14 is carry_out, bits 3:0 are the result, and bits 13:4 are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opd_a | input | 4 | First operand, A |
| opd_b | input | 4 | Second operand, B; also the shift or rotate amount |
| carry_in | input | 1 | Carry (or borrow) in for selects 0001 and 0011 |
| op_sel | input | 4 | Operation select |
| result | output | 4 | Operation result |
| carry_out | output | 1 | Raw carry out of bit 3 for the arithmetic selects, else 0 |
| zero_flag | output | 1 | Set when result is 0000 |
| led_word | output | 16 | Display word: character pair in display mode, else flags and result |

## Verification
Every combination of select, both operands and carry-in is applied, 8192 patterns in all. Each one is checked against a model in the bench that uses plain integer arithmetic and signed shifts instead of gate-level logic. Operand pairs with A below, equal to and above B separate carry from borrow in the subtract modes. Amounts of 4 to 15 separate the flushing shifts from the wrapping rotates. Negative A values separate arithmetic from logical right shifts. Toggling carry-in under every select shows that only 0001 and 0011 respond to it, and the display select shows the character pair overriding the flag layout of the display word.

// File: rtl/alu4_pkg.sv
package alu4_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'h0,
    OP_ADDC = 4'h1,
    OP_SUB  = 4'h2,
    OP_SUBB = 4'h3,
    OP_LSR  = 4'h4,
    OP_ASR  = 4'h5,
    OP_ROR  = 4'h6,
    OP_CLR  = 4'h7,
    OP_OR   = 4'h8,
    OP_AND  = 4'h9,
    OP_XOR  = 4'hA,
    OP_NOTA = 4'hB,
    OP_SHOW = 4'hC,
    OP_NAND = 4'hD,
    OP_LSL  = 4'hE,
    OP_ROL  = 4'hF
  } alu_op_e;

  // Selects that route through the shared adder
  function automatic logic op_uses_adder(input alu_op_e op);
    return (op == OP_ADD) || (op == OP_ADDC) || (op == OP_SUB) || (op == OP_SUBB);
  endfunction

  // Selects that invert B before the adder
  function automatic logic op_is_subtract(input alu_op_e op);
    return (op == OP_SUB) || (op == OP_SUBB);
  endfunction

  // Adder carry-in for each arithmetic select
  function automatic logic adder_carry_in(input alu_op_e op, input logic cin);
    logic c;
    case (op)
      OP_ADD:  c = 1'b0;
      OP_ADDC: c = cin;
      OP_SUB:  c = 1'b1;
      OP_SUBB: c = ~cin;
      default: c = 1'b0;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/alu4_full_add.sv
module alu4_full_add (
  input  logic x_i,
  input  logic y_i,
  input  logic c_i,
  output logic s_o,
  output logic c_o
);

  logic half_sum;

  assign half_sum = x_i ^ y_i;
  assign s_o      = half_sum ^ c_i;
  assign c_o      = (x_i & y_i) | (half_sum & c_i);

endmodule

// File: rtl/alu4_ripple_adder.sv
module alu4_ripple_adder #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] x_i,
  input  logic [WIDTH-1:0] y_i,
  input  logic             c_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             c_o
);

  logic [WIDTH:0] chain;

  assign chain[0] = c_i;

  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    alu4_full_add u_fa (
      .x_i (x_i[g]),
      .y_i (y_i[g]),
      .c_i (chain[g]),
      .s_o (sum_o[g]),
      .c_o (chain[g+1])
    );
  end

  assign c_o = chain[WIDTH];

endmodule

// File: rtl/alu4_shifter.sv
module alu4_shifter #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] val_i,
  input  logic [WIDTH-1:0] amt_i,
  output logic [WIDTH-1:0] lsr_o,
  output logic [WIDTH-1:0] asr_o,
  output logic [WIDTH-1:0] lsl_o,
  output logic [WIDTH-1:0] ror_o,
  output logic [WIDTH-1:0] rol_o
);

  // Right shift; beyond the top bit the fill is either zero or the sign
  function automatic logic [WIDTH-1:0] shr_f(input logic [WIDTH-1:0] v,
                                             input int unsigned k,
                                             input logic fill);
    logic [WIDTH-1:0] r;
    for (int i = 0; i < WIDTH; i++) begin
      if (i + k < WIDTH) r[i] = v[i+k];
      else               r[i] = fill;
    end
    return r;
  endfunction

  // Left shift with zero fill
  function automatic logic [WIDTH-1:0] shl_f(input logic [WIDTH-1:0] v,
                                             input int unsigned k);
    logic [WIDTH-1:0] r;
    for (int i = 0; i < WIDTH; i++) begin
      if (i >= k) r[i] = v[i-k];
      else        r[i] = 1'b0;
    end
    return r;
  endfunction

  // Rotate right; a left rotate by k is a right rotate by WIDTH - k
  function automatic logic [WIDTH-1:0] rotr_f(input logic [WIDTH-1:0] v,
                                              input int unsigned k);
    logic [WIDTH-1:0] r;
    for (int i = 0; i < WIDTH; i++) begin
      r[i] = v[(i + k) % WIDTH];
    end
    return r;
  endfunction

  int unsigned amount;
  int unsigned wrap_r;
  int unsigned wrap_l;

  always_comb begin
    amount = int'(amt_i);
    wrap_r = amount % WIDTH;
    wrap_l = (WIDTH - wrap_r) % WIDTH;
    lsr_o  = shr_f(val_i, amount, 1'b0);
    asr_o  = shr_f(val_i, amount, val_i[WIDTH-1]);
    lsl_o  = shl_f(val_i, amount);
    ror_o  = rotr_f(val_i, wrap_r);
    rol_o  = rotr_f(val_i, wrap_l);
  end

endmodule

// File: rtl/alu4_logic_unit.sv
module alu4_logic_unit #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] or_o,
  output logic [WIDTH-1:0] and_o,
  output logic [WIDTH-1:0] xor_o,
  output logic [WIDTH-1:0] nota_o,
  output logic [WIDTH-1:0] nand_o
);

  assign or_o   = a_i | b_i;
  assign and_o  = a_i & b_i;
  assign xor_o  = a_i ^ b_i;
  assign nota_o = ~a_i;
  assign nand_o = ~(a_i & b_i);

endmodule

// File: rtl/alu4_led_format.sv
module alu4_led_format #(
  parameter int               WIDTH  = 4,
  parameter int               CHAR_W = 8,
  parameter logic [CHAR_W-1:0] GLYPH_HI = 8'h4F,
  parameter logic [CHAR_W-1:0] GLYPH_LO = 8'h4B,
  localparam int              LED_W  = 2 * CHAR_W
) (
  input  logic             show_i,
  input  logic [WIDTH-1:0] res_i,
  input  logic             cout_i,
  input  logic             zero_i,
  output logic [LED_W-1:0] led_o
);

  always_comb begin
    led_o = '0;
    if (show_i) begin
      led_o = {GLYPH_HI, GLYPH_LO};
    end else begin
      led_o[WIDTH-1:0] = res_i;
      led_o[LED_W-2]   = cout_i;
      led_o[LED_W-1]   = zero_i;
    end
  end

endmodule

// File: rtl/alu4_core.sv
module alu4_core
  import alu4_pkg::*;
#(
  parameter int                WIDTH    = 4,
  parameter int                CHAR_W   = 8,
  parameter logic [CHAR_W-1:0] GLYPH_HI = 8'h4F,
  parameter logic [CHAR_W-1:0] GLYPH_LO = 8'h4B,
  localparam int               LED_W    = 2 * CHAR_W
) (
  input  logic [WIDTH-1:0] opd_a,
  input  logic [WIDTH-1:0] opd_b,
  input  logic             carry_in,
  input  logic [3:0]       op_sel,
  output logic [WIDTH-1:0] result,
  output logic             carry_out,
  output logic             zero_flag,
  output logic [LED_W-1:0] led_word
);

  alu_op_e op;

  // Named internal events, visible to the bound checker
  logic             is_arith;
  logic             is_display;
  logic [WIDTH-1:0] adder_b;
  logic             adder_cin;
  logic [WIDTH-1:0] adder_sum;
  logic             adder_cout;

  logic [WIDTH-1:0] sh_lsr, sh_asr, sh_lsl, sh_ror, sh_rol;
  logic [WIDTH-1:0] lg_or, lg_and, lg_xor, lg_nota, lg_nand;
  logic [WIDTH-1:0] res_mux;

  assign op         = alu_op_e'(op_sel);
  assign is_arith   = op_uses_adder(op);
  assign is_display = (op == OP_SHOW);

  // Subtract presents ~B; the +1 of the two's complement rides on the carry-in
  assign adder_b   = op_is_subtract(op) ? ~opd_b : opd_b;
  assign adder_cin = adder_carry_in(op, carry_in);

  alu4_ripple_adder #(.WIDTH(WIDTH)) u_adder (
    .x_i   (opd_a),
    .y_i   (adder_b),
    .c_i   (adder_cin),
    .sum_o (adder_sum),
    .c_o   (adder_cout)
  );

  alu4_shifter #(.WIDTH(WIDTH)) u_shift (
    .val_i (opd_a),
    .amt_i (opd_b),
    .lsr_o (sh_lsr),
    .asr_o (sh_asr),
    .lsl_o (sh_lsl),
    .ror_o (sh_ror),
    .rol_o (sh_rol)
  );

  alu4_logic_unit #(.WIDTH(WIDTH)) u_logic (
    .a_i    (opd_a),
    .b_i    (opd_b),
    .or_o   (lg_or),
    .and_o  (lg_and),
    .xor_o  (lg_xor),
    .nota_o (lg_nota),
    .nand_o (lg_nand)
  );

  always_comb begin
    case (op)
      OP_ADD, OP_ADDC,
      OP_SUB, OP_SUBB: res_mux = adder_sum;
      OP_LSR:          res_mux = sh_lsr;
      OP_ASR:          res_mux = sh_asr;
      OP_ROR:          res_mux = sh_ror;
      OP_CLR:          res_mux = '0;
      OP_OR:           res_mux = lg_or;
      OP_AND:          res_mux = lg_and;
      OP_XOR:          res_mux = lg_xor;
      OP_NOTA:         res_mux = lg_nota;
      OP_SHOW:         res_mux = '0;
      OP_NAND:         res_mux = lg_nand;
      OP_LSL:          res_mux = sh_lsl;
      OP_ROL:          res_mux = sh_rol;
      default:         res_mux = '0;
    endcase
  end

  assign result    = res_mux;
  assign carry_out = is_arith & adder_cout;
  assign zero_flag = ~|res_mux;

  alu4_led_format #(
    .WIDTH    (WIDTH),
    .CHAR_W   (CHAR_W),
    .GLYPH_HI (GLYPH_HI),
    .GLYPH_LO (GLYPH_LO)
  ) u_led (
    .show_i (is_display),
    .res_i  (res_mux),
    .cout_i (carry_out),
    .zero_i (zero_flag),
    .led_o  (led_word)
  );

endmodule

// File: rtl/alu4_core_chk.sv
module alu4_core_chk #(
  parameter int                WIDTH    = 4,
  parameter int                CHAR_W   = 8,
  parameter logic [CHAR_W-1:0] GLYPH_HI = 8'h4F,
  parameter logic [CHAR_W-1:0] GLYPH_LO = 8'h4B,
  localparam int               LED_W    = 2 * CHAR_W
) (
  input logic [WIDTH-1:0] opd_a,
  input logic [WIDTH-1:0] opd_b,
  input logic             carry_in,
  input logic [3:0]       op_sel,
  input logic [WIDTH-1:0] result,
  input logic             carry_out,
  input logic             zero_flag,
  input logic [LED_W-1:0] led_word,
  input logic             is_arith,
  input logic             is_display,
  input logic [WIDTH-1:0] adder_sum,
  input logic             adder_cout
);

  logic [WIDTH:0] wide_sum;
  logic [WIDTH:0] wide_sumc;

  always_comb begin
    wide_sum  = {1'b0, opd_a} + {1'b0, opd_b};
    wide_sumc = {1'b0, opd_a} + {1'b0, opd_b} + {{WIDTH{1'b0}}, carry_in};

    if (op_sel == 4'h0)
      AST_ADD_PLAIN: assert ({carry_out, result} == wide_sum) else $error("add mismatch"); // R1
    if (op_sel == 4'h1)
      AST_ADD_CARRY: assert ({carry_out, result} == wide_sumc) else $error("add with carry mismatch"); // R1
    if (op_sel == 4'h2)
      AST_SUB_PLAIN: assert (result == opd_a - opd_b && carry_out == (opd_a >= opd_b)) else $error("subtract mismatch"); // R2
    if (is_arith)
      AST_ARITH_SUM: assert (result == adder_sum && carry_out == adder_cout) else $error("adder not routed"); // R2
    if (op_sel == 4'h4 && int'(opd_b) >= WIDTH)
      AST_LSR_FLUSH: assert (result == '0) else $error("long shift not flushed"); // R3
    if (op_sel == 4'hB)
      AST_NOT_A: assert (result == ~opd_a) else $error("invert mismatch"); // R6
    if (op_sel == 4'h7)
      AST_CLEAR: assert (result == '0) else $error("clear mode nonzero"); // R7
    if (op_sel[3:2] != 2'b00)
      AST_NO_CARRY: assert (!carry_out) else $error("carry in non-arith mode"); // R8
    AST_ZERO_FLAG: assert (zero_flag == (result == '0)) else $error("zero flag mismatch"); // R9
    if (is_display)
      AST_DISPLAY: assert (led_word == {GLYPH_HI, GLYPH_LO} && !carry_out) else $error("display word wrong"); // R10
    if (!is_display)
      AST_LED_LAYOUT: assert (led_word[LED_W-1] == zero_flag && led_word[LED_W-2] == carry_out
                              && led_word[WIDTH-1:0] == result
                              && led_word[LED_W-3:WIDTH] == '0) else $error("led layout wrong"); // R11
  end

endmodule

bind alu4_core alu4_core_chk #(
  .WIDTH    (WIDTH),
  .CHAR_W   (CHAR_W),
  .GLYPH_HI (GLYPH_HI),
  .GLYPH_LO (GLYPH_LO)
) u_chk (
  .opd_a      (opd_a),
  .opd_b      (opd_b),
  .carry_in   (carry_in),
  .op_sel     (op_sel),
  .result     (result),
  .carry_out  (carry_out),
  .zero_flag  (zero_flag),
  .led_word   (led_word),
  .is_arith   (is_arith),
  .is_display (is_display),
  .adder_sum  (adder_sum),
  .adder_cout (adder_cout)
);

// File: tb/alu4_core_tb_top.sv
module alu4_core_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [3:0]  a = '0;
  logic [3:0]  b = '0;
  logic        cin = 1'b0;
  logic [3:0]  sel = '0;
  logic [3:0]  res;
  logic        cout;
  logic        zero;
  logic [15:0] led;

  alu4_core dut_i (
    .opd_a     (a),
    .opd_b     (b),
    .carry_in  (cin),
    .op_sel    (sel),
    .result    (res),
    .carry_out (cout),
    .zero_flag (zero),
    .led_word  (led)
  );

  typedef struct {
    int          op, av, bv, cv;
    logic [3:0]  res;
    logic        cout;
    logic        zero;
    logic [15:0] led;
  } exp_t;

  exp_t sb_q[$];
  int checks = 0;
  int errors = 0;
  bit driver_done = 1'b0;
  bit finished = 1'b0;

  function automatic string req_of(input int op);
    case (op)
      0, 1:     return "R1";
      2, 3:     return "R2";
      4, 14:    return "R3";
      5:        return "R4";
      6, 15:    return "R5";
      7:        return "R7";
      12:       return "R10";
      default:  return "R6";
    endcase
  endfunction

  // Reference model in integer arithmetic
  function automatic exp_t model(input int op, input int av, input int bv, input int cv);
    exp_t e;
    int r, c, s, k;
    r = 0; c = 0;
    case (op)
      0:  begin s = av + bv;       r = s % 16; c = s / 16; end
      1:  begin s = av + bv + cv;  r = s % 16; c = s / 16; end
      2:  begin s = av - bv;       r = (s + 16) % 16; c = (s >= 0) ? 1 : 0; end
      3:  begin s = av - bv - cv;  r = (s + 16) % 16; c = (s >= 0) ? 1 : 0; end
      4:  r = (bv >= 4) ? 0 : (av >> bv);
      5:  begin s = (av >= 8) ? av - 16 : av; s = s >>> bv; r = s & 15; end
      6:  begin k = bv % 4; r = ((av >> k) | (av << (4 - k))) & 15; end
      7:  r = 0;
      8:  r = av | bv;
      9:  r = av & bv;
      10: r = av ^ bv;
      11: r = 15 - av;
      12: r = 0;
      13: r = 15 - (av & bv);
      14: r = (av << bv) & 15;
      default: begin k = bv % 4; r = ((av << k) | (av >> (4 - k))) & 15; end
    endcase
    e.op = op; e.av = av; e.bv = bv; e.cv = cv;
    e.res  = 4'(r);
    e.cout = (c != 0);
    e.zero = (r == 0);
    if (op == 12) e.led = 16'h4F4B;
    else          e.led = {e.zero, e.cout, 10'b0, 4'(r)};
    return e;
  endfunction

  task automatic drive(input int op, input int av, input int bv, input int cv);
    @(posedge clk);
    #1;
    sel = 4'(op); a = 4'(av); b = 4'(bv); cin = (cv != 0);
    sb_q.push_back(model(op, av, bv, cv));
  endtask

  task automatic check(input string req, input string what, input int act, input int exp, input exp_t e);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: op=%0d a=%0d b=%0d cin=%0d actual=%0h expected=%0h",
               req, what, e.op, e.av, e.bv, e.cv, act, exp);
    end
  endtask

  // Monitor: compares on the falling edge, half a cycle after the inputs settle
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      check(req_of(e.op), "result", int'(res), int'(e.res), e);
      check((e.op >= 4) ? "R8" : req_of(e.op), "carry", int'(cout), int'(e.cout), e);
      check("R9", "zero", int'(zero), int'(e.zero), e);
      check((e.op == 12) ? "R10" : "R11", "led", int'(led), int'(e.led), e);
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // Reset state: all-zero inputs give zero result, zero flag set (R9, R11)
    #2;
    checks++;
    if (res !== 4'h0 || zero !== 1'b1 || led !== 16'h8000) begin
      errors++;
      $display("FAIL R11 idle: actual=%0h expected=8000", led);
    end
    // Exhaustive sweep: select, A, B and carry-in
    for (int op = 0; op < 16; op++)
      for (int av = 0; av < 16; av++)
        for (int bv = 0; bv < 16; bv++)
          for (int cv = 0; cv < 2; cv++)
            drive(op, av, bv, cv);
    driver_done = 1'b1;
  end

  initial begin
    wait (driver_done && sb_q.size() == 0);
    @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule